// File: doc/BRIEF.md
# Prioritized Pending Interrupt Selector

This block keeps one pending flag for each of thirteen asynchronous interrupt sources: reset, machine check, hypervisor decrementer, external, critical external, watchdog, critical doorbell, fixed-interval timer, programmable interval timer, decrementer, doorbell, performance monitor and thermal. Timers and message logic raise a flag by pulsing its set line. The flag then stays up until the selector clears it.

In each cycle the selector does three things. It masks the flags with the current processor state: the external enable, the critical enable, the hypervisor state, the partition routing bit, and a hypervisor decrementer enable. It then picks the highest-priority source that is left. Finally it issues a one-cycle take pulse together with the cause, in both one-hot and encoded form. When a source is taken, its flag is cleared, except for sources that are level-driven or configured to persist. The downstream sequencer saves context and computes the handler address. While that sequencer is working it holds the busy input high.

Top module: `irq_pick_top`

## Requirements
- R1: After a synchronous reset the block is idle: `pend_o` is zero, `irq_req` is 0, `take` is 0, `cause_oh` is zero and `cause_id` is 0.
- R2: A high `set_req[i]` at a clock edge makes `pend_o[i]` 1 from that edge on. `irq_req` is 1 exactly while any pending bit is set, including after a delivery that leaves other bits pending.
- R3: Bit positions, which are also the `cause_id` codes, follow priority from highest to lowest: 0 reset, 1 machine check, 2 hypervisor decrementer, 3 external, 4 critical external, 5 watchdog, 6 critical doorbell, 7 fixed-interval timer, 8 programmable interval timer, 9 decrementer, 10 doorbell, 11 performance monitor, 12 thermal. The lowest-numbered eligible pending source is delivered one edge later: `take` goes to 1, `cause_oh` holds that single bit and `cause_id` holds its index. Without a take, both cause outputs are zero.
- R4: Reset and machine check are eligible regardless of the state inputs, and delivery clears their pending bit.
- R5: The hypervisor decrementer is eligible only when `hdec_en` is 1 and either `st_ee` is 1 or `st_hv` is 0. Delivery clears it.
- R6: The external source is eligible when `st_ee` is 1, or when hypervisor support is built in (`HV_IMPL`=1, the default) with `st_hv`=0 and `st_lpes0`=0. Its pending bit is left set on delivery.
- R7: The critical external source is eligible only when `st_ce` is 1. Its pending bit is left set on delivery.
- R8: Sources 5 to 12 are eligible only when `st_ee` is 1. Delivery clears the taken bit, with the exception in R9.
- R9: Delivery of the decrementer (bit 9) clears its pending bit only when `dec_clr_mode` is 1. Otherwise the bit stays set.
- R10: A set request on the same edge as a delivery clear of that bit leaves the bit set.
- R11: `take` is never high on two consecutive cycles. No take follows a cycle in which `ack_busy` was 1.
- R12: An ineligible pending source of higher priority does not block an eligible one of lower priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| set_req | input | 13 | Per-source pending set pulses |
| st_ee | input | 1 | External interrupt enable state bit |
| st_ce | input | 1 | Critical interrupt enable state bit |
| st_hv | input | 1 | Hypervisor state bit |
| st_lpes0 | input | 1 | Partition routing bit for external interrupts |
| hdec_en | input | 1 | Hypervisor decrementer enable |
| dec_clr_mode | input | 1 | Decrementer clear-on-delivery select |
| ack_busy | input | 1 | Downstream sequencer busy; blocks takes |
| pend_o | output | 13 | Pending flags |
| irq_req | output | 1 | Any source pending |
| take | output | 1 | One-cycle delivery strobe |
| cause_oh | output | 13 | One-hot cause of the current take |
| cause_id | output | 4 | Encoded cause of the current take |

## Verification
A wrong clear policy shows on `pend_o` on the edge that delivers the source. A level-driven bit that vanishes, or a one-shot bit that stays, can be seen right after the `take` pulse. A wrong gating term or a wrong priority link shows as the wrong `cause_id`, or as a missing or extra `take`, one edge after the state inputs settle. A broken pulse or busy interlock shows as `take` staying high across two samples while a persistent source is pending.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;

    localparam int NSRC = 13;
    localparam int IDW  = $clog2(NSRC);

    // Source index equals priority rank (0 = highest).
    typedef enum logic [IDW-1:0] {
        SRC_RST   = 4'd0,
        SRC_MCK   = 4'd1,
        SRC_HDEC  = 4'd2,
        SRC_EXT   = 4'd3,
        SRC_CEXT  = 4'd4,
        SRC_WDOG  = 4'd5,
        SRC_CDBL  = 4'd6,
        SRC_FIT   = 4'd7,
        SRC_PIT   = 4'd8,
        SRC_DEC   = 4'd9,
        SRC_DBL   = 4'd10,
        SRC_PERF  = 4'd11,
        SRC_THERM = 4'd12
    } src_e;

    localparam int EE_LO = int'(SRC_WDOG);
    localparam int EE_HI = int'(SRC_THERM);

    typedef struct packed {
        logic ee;
        logic ce;
        logic hv;
        logic lpes0;
        logic hden;
        logic dec_clr;
    } ctl_t;

    // Which sources lose their pending flag when delivered.
    function automatic logic [NSRC-1:0] clear_policy(input logic dec_clr);
        logic [NSRC-1:0] m;
        m = '1;
        m[SRC_EXT]  = 1'b0;
        m[SRC_CEXT] = 1'b0;
        m[SRC_DEC]  = dec_clr;
        return m;
    endfunction

    // Per-source permission from the processor state.
    function automatic logic [NSRC-1:0] allow_mask(input ctl_t c, input logic hv_impl);
        logic [NSRC-1:0] a;
        a = '0;
        a[SRC_RST]  = 1'b1;
        a[SRC_MCK]  = 1'b1;
        a[SRC_HDEC] = c.hden & (c.ee | ~c.hv);
        a[SRC_EXT]  = c.ee | (hv_impl & ~c.hv & ~c.lpes0);
        a[SRC_CEXT] = c.ce;
        for (int i = EE_LO; i <= EE_HI; i++) begin
            a[i] = c.ee;
        end
        return a;
    endfunction

endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
    parameter int N = 13
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] pend_o
);

    logic [N-1:0] pend_q;

    for (genvar g = 0; g < N; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                pend_q[g] <= 1'b0;
            end else if (set_i[g]) begin
                pend_q[g] <= 1'b1;          // set has precedence over clear
            end else if (clr_i[g]) begin
                pend_q[g] <= 1'b0;
            end
        end

        AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
            set_i[g] |=> pend_q[g]);                                  // R10
        AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
            (!set_i[g] && !clr_i[g]) |=> (pend_q[g] == $past(pend_q[g]))); // R2
    end

    assign pend_o = pend_q;

endmodule

// File: rtl/irq_gate.sv
module irq_gate
    import irq_sel_pkg::*;
#(
    parameter logic HV_IMPL = 1'b1
) (
    input  logic [NSRC-1:0] pend_i,
    input  ctl_t            ctl_i,
    output logic [NSRC-1:0] elig_o
);

    logic [NSRC-1:0] allow;

    always_comb begin
        allow  = allow_mask(ctl_i, HV_IMPL);
        elig_o = pend_i & allow;
    end

    AST_ELIG_SUBSET: assert final ((elig_o & ~pend_i) == '0);         // R12

endmodule

// File: rtl/irq_prio.sv
module irq_prio #(
    parameter int N   = 13,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req_i,
    output logic [N-1:0]  grant_o,
    output logic [IW-1:0] idx_o,
    output logic          found_o
);

    logic [N:0] seen;

    assign seen[0] = 1'b0;

    for (genvar g = 0; g < N; g++) begin : g_chain
        assign grant_o[g]  = req_i[g] & ~seen[g];
        assign seen[g+1]   = seen[g] | req_i[g];
    end

    assign found_o = seen[N];

    always_comb begin
        idx_o = '0;
        for (int i = 0; i < N; i++) begin
            if (grant_o[i]) begin
                idx_o = IW'(i);
            end
        end
    end

    AST_GRANT_ONE: assert final ($onehot0(grant_o));                  // R3
    AST_FOUND_GRANT: assert final (found_o == (grant_o != '0));        // R3

endmodule

// File: rtl/irq_pick_top.sv
module irq_pick_top
    import irq_sel_pkg::*;
#(
    parameter logic HV_IMPL = 1'b1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [12:0]     set_req,
    input  logic            st_ee,
    input  logic            st_ce,
    input  logic            st_hv,
    input  logic            st_lpes0,
    input  logic            hdec_en,
    input  logic            dec_clr_mode,
    input  logic            ack_busy,
    output logic [12:0]     pend_o,
    output logic            irq_req,
    output logic            take,
    output logic [12:0]     cause_oh,
    output logic [3:0]      cause_id
);

    ctl_t            ctl;
    logic [NSRC-1:0] pend;
    logic [NSRC-1:0] elig;
    logic [NSRC-1:0] grant;
    logic [IDW-1:0]  win_id;
    logic            found;
    logic            take_d;
    logic [NSRC-1:0] clr;

    logic            take_q;
    logic [NSRC-1:0] cause_oh_q;
    logic [IDW-1:0]  cause_id_q;

    always_comb begin
        ctl.ee      = st_ee;
        ctl.ce      = st_ce;
        ctl.hv      = st_hv;
        ctl.lpes0   = st_lpes0;
        ctl.hden    = hdec_en;
        ctl.dec_clr = dec_clr_mode;
    end

    irq_pend_bank #(.N(NSRC)) u_bank (
        .clk    (clk),
        .rst    (rst),
        .set_i  (set_req),
        .clr_i  (clr),
        .pend_o (pend)
    );

    irq_gate #(.HV_IMPL(HV_IMPL)) u_gate (
        .pend_i (pend),
        .ctl_i  (ctl),
        .elig_o (elig)
    );

    irq_prio #(.N(NSRC)) u_prio (
        .req_i   (elig),
        .grant_o (grant),
        .idx_o   (win_id),
        .found_o (found)
    );

    // A delivery needs a winner, an idle sequencer and a gap after the last pulse.
    assign take_d = found & ~ack_busy & ~take_q;
    assign clr    = take_d ? (grant & clear_policy(dec_clr_mode)) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            take_q     <= 1'b0;
            cause_oh_q <= '0;
            cause_id_q <= '0;
        end else begin
            take_q     <= take_d;
            cause_oh_q <= take_d ? grant  : '0;
            cause_id_q <= take_d ? win_id : '0;
        end
    end

    assign pend_o   = pend;
    assign irq_req  = |pend;
    assign take     = take_q;
    assign cause_oh = cause_oh_q;
    assign cause_id = cause_id_q;

    AST_TAKE_PULSE: assert property (@(posedge clk) disable iff (rst)
        take |=> !take);                                              // R11
    AST_BUSY_BLOCK: assert property (@(posedge clk) disable iff (rst)
        ack_busy |=> !take);                                          // R11
    AST_CAUSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        take |-> ($countones(cause_oh) == 1));                        // R3
    AST_CAUSE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !take |-> (cause_oh == '0 && cause_id == '0));                // R3
    AST_EXT_KEEP: assert property (@(posedge clk) disable iff (rst)
        (take && cause_oh[SRC_EXT]) |-> pend_o[SRC_EXT]);             // R6
    AST_CEXT_KEEP: assert property (@(posedge clk) disable iff (rst)
        (take && cause_oh[SRC_CEXT]) |-> pend_o[SRC_CEXT]);           // R7
    AST_RST_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (take && cause_oh[SRC_RST] && !$past(set_req[SRC_RST])) |-> !pend_o[SRC_RST]); // R4
    AST_HDEC_GATE: assert property (@(posedge clk) disable iff (rst)
        (take && cause_oh[SRC_HDEC]) |-> $past(hdec_en && (st_ee || !st_hv))); // R5
    AST_EE_GROUP: assert property (@(posedge clk) disable iff (rst)
        (take && (cause_oh[EE_HI:EE_LO] != '0)) |-> $past(st_ee));     // R8
    AST_CEXT_GATE: assert property (@(posedge clk) disable iff (rst)
        (take && cause_oh[SRC_CEXT]) |-> $past(st_ce));               // R7
    AST_REQ_LEVEL: assert property (@(posedge clk) disable iff (rst)
        irq_req == (pend_o != '0));                                   // R2

endmodule

// File: tb/sim_irq_pick_top.sv
module sim_irq_pick_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [12:0] set_req = '0;
    logic        st_ee = 0, st_ce = 0, st_hv = 0, st_lpes0 = 0;
    logic        hdec_en = 0, dec_clr_mode = 0, ack_busy = 1'b1;
    logic [12:0] pend_o;
    logic        irq_req;
    logic        take;
    logic [12:0] cause_oh;
    logic [3:0]  cause_id;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    irq_pick_top u0 (
        .clk(clk), .rst(rst), .set_req(set_req),
        .st_ee(st_ee), .st_ce(st_ce), .st_hv(st_hv), .st_lpes0(st_lpes0),
        .hdec_en(hdec_en), .dec_clr_mode(dec_clr_mode), .ack_busy(ack_busy),
        .pend_o(pend_o), .irq_req(irq_req), .take(take),
        .cause_oh(cause_oh), .cause_id(cause_id)
    );

    // cfg = {ee, ce, hv, lpes0, hden, dec_clr}
    typedef struct packed {
        logic [12:0] mask;
        logic [5:0]  cfg;
        logic        etake;
        logic [3:0]  eid;
        logic [12:0] epend;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t TBL [NV] = '{
        '{13'h1FFF, 6'b000000, 1'b1, 4'd0,  13'h1FFE},  // R3 R4 reset wins
        '{13'h0002, 6'b000000, 1'b1, 4'd1,  13'h0000},  // R4 machine check
        '{13'h0004, 6'b001010, 1'b0, 4'd0,  13'h0004},  // R5 ee0 hv1 blocks
        '{13'h0004, 6'b000010, 1'b1, 4'd2,  13'h0000},  // R5 hv0 allows
        '{13'h0004, 6'b100000, 1'b0, 4'd0,  13'h0004},  // R5 enable off
        '{13'h0008, 6'b100000, 1'b1, 4'd3,  13'h0008},  // R6 ee path, kept
        '{13'h0008, 6'b000000, 1'b1, 4'd3,  13'h0008},  // R6 hv0 lpes0=0 path
        '{13'h0008, 6'b000100, 1'b0, 4'd0,  13'h0008},  // R6 lpes0 blocks
        '{13'h0010, 6'b010000, 1'b1, 4'd4,  13'h0010},  // R7 ce, kept
        '{13'h0010, 6'b100000, 1'b0, 4'd0,  13'h0010},  // R7 ce0 blocks
        '{13'h1FE0, 6'b000000, 1'b0, 4'd0,  13'h1FE0},  // R8 ee0 blocks group
        '{13'h1FE0, 6'b100000, 1'b1, 4'd5,  13'h1FC0},  // R8 watchdog first
        '{13'h1F80, 6'b100000, 1'b1, 4'd7,  13'h1F00},  // R3 fit before pit
        '{13'h1000, 6'b100000, 1'b1, 4'd12, 13'h0000},  // R8 thermal last
        '{13'h0200, 6'b100000, 1'b1, 4'd9,  13'h0200},  // R9 dec kept
        '{13'h0200, 6'b100001, 1'b1, 4'd9,  13'h0000},  // R9 dec cleared
        '{13'h0014, 6'b110000, 1'b1, 4'd4,  13'h0014},  // R12 hdec skipped
        '{13'h0C00, 6'b100000, 1'b1, 4'd10, 13'h0800}   // R3 doorbell over perf
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; set_req = '0; ack_busy = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic set_cfg(input logic [5:0] c);
        {st_ee, st_ce, st_hv, st_lpes0, hdec_en, dec_clr_mode} = c;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        do_reset();
        check("R1 pend", int'(pend_o), 0);
        check("R1 irq_req", int'(irq_req), 0);
        check("R1 take", int'(take), 0);
        check("R1 cause_oh", int'(cause_oh), 0);
        check("R1 cause_id", int'(cause_id), 0);

        // Vector table
        for (int v = 0; v < NV; v++) begin
            do_reset();
            set_cfg(TBL[v].cfg);
            set_req = TBL[v].mask; ack_busy = 1'b1;
            @(negedge clk);
            set_req = '0; ack_busy = 1'b0;
            @(negedge clk);
            check($sformatf("R3 take v%0d", v), int'(take), int'(TBL[v].etake));
            check($sformatf("R3 id v%0d", v), int'(cause_id), int'(TBL[v].eid));
            check($sformatf("R3 onehot v%0d", v), int'(cause_oh),
                  TBL[v].etake ? (1 << TBL[v].eid) : 0);
            check($sformatf("R4 pend v%0d", v), int'(pend_o), int'(TBL[v].epend));
        end

        // R2 set and request line, no take while busy
        do_reset();
        set_cfg(6'b100000);
        set_req = 13'h0080; ack_busy = 1'b1;
        @(negedge clk);
        set_req = '0;
        check("R2 pend set", int'(pend_o), 'h80);
        check("R2 irq_req", int'(irq_req), 1);
        @(negedge clk);
        check("R11 busy blocks", int'(take), 0);

        // R2 request stays up after a delivery that leaves bits pending
        do_reset();
        set_cfg(6'b100000);
        set_req = 13'h0060; ack_busy = 1'b1;
        @(negedge clk);
        set_req = '0; ack_busy = 1'b0;
        @(negedge clk);
        check("R2 take wdog", int'(cause_id), 5);
        check("R2 pend rest", int'(pend_o), 'h40);
        check("R2 irq_req kept", int'(irq_req), 1);

        // R10 set on the same edge as clear
        do_reset();
        set_cfg(6'b100000);
        set_req = 13'h0020; ack_busy = 1'b1;
        @(negedge clk);
        ack_busy = 1'b0; set_req = 13'h0020;
        @(negedge clk);
        set_req = '0;
        check("R10 take", int'(take), 1);
        check("R10 pend kept", int'(pend_o), 'h20);

        // R11 pulse spacing with a level-driven source
        do_reset();
        set_cfg(6'b100000);
        set_req = 13'h0008; ack_busy = 1'b1;
        @(negedge clk);
        set_req = '0; ack_busy = 1'b0;
        @(negedge clk);
        check("R11 first take", int'(take), 1);
        @(negedge clk);
        check("R11 gap", int'(take), 0);
        @(negedge clk);
        check("R11 second take", int'(take), 1);
        ack_busy = 1'b1;
        @(negedge clk);
        check("R11 busy gap", int'(take), 0);
        @(negedge clk);
        check("R11 busy hold", int'(take), 0);
        check("R6 ext kept", int'(pend_o), 'h8);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule